// File: doc/BRIEF.md
# Display Controller Host Command Port

This block is the microcontroller-facing front end of a small dot-matrix display controller. Each bus cycle is one strobe carrying an 8-bit byte, a select line that chooses command space (0) or display-memory space (1), and a direction line (1 = read). Command writes set the scan-mirror, power-down, addressing-direction and instruction-page flags, the display mode, and the display-memory pointer. Command reads return a packed status byte. Data writes and reads reach an internal display memory of 102 columns by 9 pages of 8 bits, at a column/page pointer that advances by itself after every data access.

The block drives the flag outputs used by the panel-scanning logic. In power-down it reports the display mode as off, but it keeps memory contents and still serves data reads and writes. Read results appear one cycle after the read strobe, qualified by a one-cycle valid pulse.

Top module: `dcpTop`

## Requirements
- R1: After reset the pointer is column 0, page 0. The power-down flag is 1. The display mode is off (00). The bit-order flag is 0. Both mirror flags, the vertical flag and the extended flag are 0.
- R2: A command write whose bits [7:5] are 001 is accepted whatever the extended flag holds. It loads, from bit 4 down to bit 0: column mirror, row mirror, power-down, vertical addressing, extended set. The flag outputs show the new values from the next cycle.
- R3: A command read returns a status byte. Its layout is bit7 = power-down, bits 6:5 = 0, bit4 = mode bit D, bit3 = mode bit E, bit2 = column mirror, bit1 = row mirror, bit0 = bit-order flag.
- R4: With the extended flag 0, a command write of the form 00001DOE (bits [7:3] = 00001) sets D from bit 2, the bit-order flag from bit 1 and E from bit 0. With the extended flag 1, the same command is ignored.
- R5: With the extended flag 0, command 1ccccccc loads column c and command 0100pppp loads page p. A column of 102 or more, or a page of 9 or more, is ignored. Both commands are ignored while the extended flag is 1.
- R6: A data write stores the byte at the current column/page. In horizontal mode the column then increments, wraps from 101 to 0, and leaves the page unchanged.
- R7: A data read returns the memory byte at the current column/page, and the pointer then advances exactly as it does after a write.
- R8: In vertical mode each data access increments the page. From page 8 the page wraps to 0 and the column advances by one, with the column wrapping from 101 to 0.
- R9: While power-down is 1 the display-mode output is 00 (off), whatever D and E hold. Data reads and writes still work, and memory contents survive entry to and exit from power-down.
- R10: The display-mode output encodes {D,E}: 00 off, 01 all on, 10 normal, 11 inverse. Read data is valid exactly one cycle after a read strobe, marked by a one-cycle valid pulse. The valid output is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | One-cycle bus strobe |
| busSel | input | 1 | 0 = command space, 1 = display memory |
| busRead | input | 1 | 1 = read cycle, 0 = write cycle |
| busWrData | input | 8 | Write byte |
| rdData | output | 8 | Read result (status or memory byte) |
| rdValid | output | 1 | Read result valid pulse |
| scanColRev | output | 1 | Column scan mirrored |
| scanRowRev | output | 1 | Row scan mirrored |
| pwrDown | output | 1 | Power-down flag |
| vertAddr | output | 1 | Vertical addressing selected |
| extSet | output | 1 | Extended command page selected |
| dispMode | output | 2 | Effective display mode {D,E}, forced 00 in power-down |
| lsbTop | output | 1 | Bit-order flag (1 = bit 0 on top row) |

## Verification
A wrong flag register shows on its output pin in the cycle after the command, and in the status byte one cycle after a command read. A pointer that has drifted or wrapped wrongly is invisible until the next data read, which returns a byte from the wrong cell one cycle after its strobe. The bench therefore writes distinct bytes across the column and page wrap points and reads them back through reloaded pointers. This makes any increment, wrap or ignored-load fault show up as a data mismatch.

// File: rtl/dcpPkg.sv
package dcpPkg;

  typedef struct packed {
    logic fnSet;
    logic dispSet;
    logic colLoad;
    logic pageLoad;
    logic memWr;
    logic memRd;
    logic statRd;
  } ctrlStrobes_t;

  localparam logic [2:0] FNSET_TAG = 3'b001;
  localparam logic [4:0] DISP_TAG  = 5'b00001;
  localparam logic [3:0] PAGE_TAG  = 4'b0100;

endpackage

// File: rtl/dcpCtrl.sv
module dcpCtrl
  import dcpPkg::*;
(
  input  logic        busValid,
  input  logic        busSel,
  input  logic        busRead,
  input  logic [7:0]  busWrData,
  input  logic        extSet,
  output ctrlStrobes_t strobes
);

  logic cmdWr;
  logic cmdRd;
  logic basicPage;

  always_comb begin
    cmdWr     = busValid && !busSel && !busRead;
    cmdRd     = busValid && !busSel &&  busRead;
    basicPage = !extSet;

    strobes          = '0;
    strobes.statRd   = cmdRd;
    strobes.memWr    = busValid && busSel && !busRead;
    strobes.memRd    = busValid && busSel &&  busRead;
    strobes.fnSet    = cmdWr && (busWrData[7:5] == FNSET_TAG);
    strobes.colLoad  = cmdWr && basicPage && busWrData[7];
    strobes.pageLoad = cmdWr && basicPage && (busWrData[7:4] == PAGE_TAG);
    strobes.dispSet  = cmdWr && basicPage && (busWrData[7:3] == DISP_TAG);
  end

endmodule

// File: rtl/dcpData.sv
module dcpData
  import dcpPkg::*;
#(
  parameter int NUM_COLS  = 102,
  parameter int NUM_PAGES = 9,
  parameter int DATA_W    = 8,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int MEM_SZ   = NUM_COLS * NUM_PAGES,
  localparam int ADDR_W   = $clog2(MEM_SZ)
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              scanColRev,
  output logic              scanRowRev,
  output logic              pwrDown,
  output logic              vertAddr,
  output logic              extSet,
  output logic [1:0]        dispMode,
  output logic              lsbTop,
  output logic [COL_W-1:0]  colPtr,
  output logic [PAGE_W-1:0] pagePtr
);

  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic modeD;
  logic modeE;
  logic memAccess;
  logic [COL_W-1:0]  colStep;
  logic [COL_W-1:0]  nextCol;
  logic [PAGE_W-1:0] nextPage;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] statusByte;
  logic [6:0]        loadCol;
  logic [3:0]        loadPage;
  logic              colInRange;
  logic              pageInRange;
  logic [DATA_W-1:0] mem [MEM_SZ];

  // mode flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanColRev <= 1'b0;
      scanRowRev <= 1'b0;
      pwrDown    <= 1'b1;
      vertAddr   <= 1'b0;
      extSet     <= 1'b0;
      modeD      <= 1'b0;
      modeE      <= 1'b0;
      lsbTop     <= 1'b0;
    end else begin
      if (strobes.fnSet) begin
        scanColRev <= busWrData[4];
        scanRowRev <= busWrData[3];
        pwrDown    <= busWrData[2];
        vertAddr   <= busWrData[1];
        extSet     <= busWrData[0];
      end
      if (strobes.dispSet) begin
        modeD  <= busWrData[2];
        lsbTop <= busWrData[1];
        modeE  <= busWrData[0];
      end
    end
  end

  assign dispMode = pwrDown ? 2'b00 : {modeD, modeE};

  // pointer advance
  always_comb begin
    memAccess = strobes.memWr || strobes.memRd;
    colStep   = (colPtr == LAST_COL) ? '0 : colPtr + COL_W'(1);
    if (!vertAddr) begin
      nextCol  = colStep;
      nextPage = pagePtr;
    end else if (pagePtr == LAST_PAGE) begin
      nextCol  = colStep;
      nextPage = '0;
    end else begin
      nextCol  = colPtr;
      nextPage = pagePtr + PAGE_W'(1);
    end
  end

  always_comb begin
    loadCol     = busWrData[6:0];
    loadPage    = busWrData[3:0];
    colInRange  = (32'(loadCol)  < NUM_COLS);
    pageInRange = (32'(loadPage) < NUM_PAGES);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colPtr  <= '0;
      pagePtr <= '0;
    end else if (memAccess) begin
      colPtr  <= nextCol;
      pagePtr <= nextPage;
    end else begin
      if (strobes.colLoad && colInRange)
        colPtr <= COL_W'(loadCol);
      if (strobes.pageLoad && pageInRange)
        pagePtr <= PAGE_W'(loadPage);
    end
  end

  // display memory
  assign memAddr = ADDR_W'(pagePtr) * ADDR_W'(NUM_COLS) + ADDR_W'(colPtr);

  always_ff @(posedge clk) begin
    if (strobes.memWr)
      mem[memAddr] <= busWrData;
  end

  assign statusByte = {pwrDown, 2'b00, modeD, modeE, scanColRev, scanRowRev, lsbTop};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.memRd || strobes.statRd;
      if (strobes.statRd)
        rdData <= statusByte;
      else if (strobes.memRd)
        rdData <= mem[memAddr];
    end
  end

endmodule

// File: rtl/dcpTop.sv
module dcpTop
  import dcpPkg::*;
#(
  parameter int NUM_COLS  = 102,
  parameter int NUM_PAGES = 9
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic       busSel,
  input  logic       busRead,
  input  logic [7:0] busWrData,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       scanColRev,
  output logic       scanRowRev,
  output logic       pwrDown,
  output logic       vertAddr,
  output logic       extSet,
  output logic [1:0] dispMode,
  output logic       lsbTop
);

  localparam int COL_W  = $clog2(NUM_COLS);
  localparam int PAGE_W = $clog2(NUM_PAGES);

  ctrlStrobes_t      strobes;
  logic [COL_W-1:0]  colPtr;
  logic [PAGE_W-1:0] pagePtr;

  dcpCtrl u_ctrl (
    .busValid  (busValid),
    .busSel    (busSel),
    .busRead   (busRead),
    .busWrData (busWrData),
    .extSet    (extSet),
    .strobes   (strobes)
  );

  dcpData #(
    .NUM_COLS  (NUM_COLS),
    .NUM_PAGES (NUM_PAGES),
    .DATA_W    (8)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWrData  (busWrData),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .scanColRev (scanColRev),
    .scanRowRev (scanRowRev),
    .pwrDown    (pwrDown),
    .vertAddr   (vertAddr),
    .extSet     (extSet),
    .dispMode   (dispMode),
    .lsbTop     (lsbTop),
    .colPtr     (colPtr),
    .pagePtr    (pagePtr)
  );

endmodule

// File: rtl/dcpChecker.sv
module dcpChecker #(
  parameter int NUM_COLS  = 102,
  parameter int NUM_PAGES = 9,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int PAGE_W   = $clog2(NUM_PAGES)
)(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busSel,
  input logic              busRead,
  input logic [7:0]        busWrData,
  input logic              rdValid,
  input logic              scanColRev,
  input logic              scanRowRev,
  input logic              pwrDown,
  input logic              vertAddr,
  input logic              extSet,
  input logic [COL_W-1:0]  colPtr,
  input logic [PAGE_W-1:0] pagePtr
);

  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic dataAcc;
  logic fnCmd;
  assign dataAcc = busValid && busSel;
  assign fnCmd   = busValid && !busSel && !busRead && (busWrData[7:5] == 3'b001);

  AST_FNSET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    fnCmd |=> ({scanColRev, scanRowRev, pwrDown, vertAddr, extSet} == $past(busWrData[4:0]))); // R2

  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(colPtr) < NUM_COLS); // R5

  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(pagePtr) < NUM_PAGES); // R5

  AST_HORZ_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !vertAddr && colPtr == LAST_COL) |=> (colPtr == '0)); // R6

  AST_HORZ_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !vertAddr) |=> $stable(pagePtr)); // R6

  AST_VERT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && vertAddr && pagePtr != LAST_PAGE) |=> (pagePtr == $past(pagePtr) + PAGE_W'(1) && $stable(colPtr))); // R8

  AST_VERT_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && vertAddr && pagePtr == LAST_PAGE && colPtr != LAST_COL) |=> (pagePtr == '0 && colPtr == $past(colPtr) + COL_W'(1))); // R8

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busRead) |=> rdValid); // R10

  AST_NO_STRAY_RD: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busRead) |=> !rdValid); // R10

endmodule

bind dcpTop dcpChecker #(.NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES)) u_dcpChecker (
  .clk        (clk),
  .rstN       (rstN),
  .busValid   (busValid),
  .busSel     (busSel),
  .busRead    (busRead),
  .busWrData  (busWrData),
  .rdValid    (rdValid),
  .scanColRev (scanColRev),
  .scanRowRev (scanRowRev),
  .pwrDown    (pwrDown),
  .vertAddr   (vertAddr),
  .extSet     (extSet),
  .colPtr     (colPtr),
  .pagePtr    (pagePtr)
);

// File: tb/test_dcpTop.sv
`timescale 1ns/1ps
module test_dcpTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busValid = 1'b0;
  logic       busSel = 1'b0;
  logic       busRead = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] rdData;
  logic       rdValid;
  logic       scanColRev, scanRowRev, pwrDown, vertAddr, extSet, lsbTop;
  logic [1:0] dispMode;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  dcpTop i_dcpTop (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busSel(busSel), .busRead(busRead),
    .busWrData(busWrData), .rdData(rdData), .rdValid(rdValid),
    .scanColRev(scanColRev), .scanRowRev(scanRowRev), .pwrDown(pwrDown),
    .vertAddr(vertAddr), .extSet(extSet), .dispMode(dispMode), .lsbTop(lsbTop)
  );

  task automatic check(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] status(input bit pd, input bit d, input bit e,
                                        input bit mx, input bit my, input bit lo);
    return {pd, 2'b00, d, e, mx, my, lo};
  endfunction

  task automatic busOp(input bit sel, input bit rd, input logic [7:0] val);
    @(negedge clk);
    busValid  = 1'b1;
    busSel    = sel;
    busRead   = rd;
    busWrData = val;
    @(negedge clk);
    busValid  = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] val);
    busOp(1'b0, 1'b0, val);
  endtask

  task automatic wr(input logic [7:0] val);
    busOp(1'b1, 1'b0, val);
  endtask

  task automatic rdExpect(input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busOp(1'b1, 1'b1, 8'h00);
  endtask

  task automatic statExpect(input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busOp(1'b0, 1'b1, 8'h00);
  endtask

  task automatic setPtr(input int col, input int page);
    cmd(8'h80 | 8'(col));
    cmd(8'h40 | 8'(page));
  endtask

  // monitor: pops expected read results as the design produces them
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected read pulse", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, int'(rdData), int'(e));
      end
    end
  end

  task automatic finish();
    if (expQ.size() != 0)
      check("R10 missing read results", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pwrDown", pwrDown, 1);
    check("R1 dispMode", dispMode, 0);
    check("R1 flags", {scanColRev, scanRowRev, vertAddr, extSet, lsbTop}, 0);
    check("R10 rdValid idle", rdValid, 0);
    statExpect(status(1,0,0,0,0,0), "R3 status after reset");

    // R2 function set: MX=1, PD=1
    cmd(8'h34);
    check("R2 column mirror", scanColRev, 1);
    check("R2 row mirror", scanRowRev, 0);
    check("R2 power-down", pwrDown, 1);
    statExpect(status(1,0,0,1,0,0), "R3 status mirror");

    // wake, normal mode with bit0 on top
    cmd(8'h20);
    check("R2 wake", pwrDown, 0);
    cmd(8'h0E);
    check("R4 normal mode", dispMode, 2'b10);
    check("R4 bit order", lsbTop, 1);
    statExpect(status(0,1,0,0,0,1), "R3 status normal");

    // R6 horizontal wrap, page kept
    setPtr(100, 3);
    wr(8'hA1);
    wr(8'hB2);
    wr(8'hC3);
    check("R10 no pulse after write", rdValid, 0);
    setPtr(100, 3);
    rdExpect(8'hA1, "R7 read col100");
    rdExpect(8'hB2, "R7 read col101 (read advanced pointer)");
    rdExpect(8'hC3, "R6 wrap to col0 same page");

    // R4/R5 ignored in extended page
    setPtr(5, 0);
    cmd(8'h21);
    check("R2 extended flag", extSet, 1);
    cmd(8'h80);
    cmd(8'h42);
    cmd(8'h09);
    check("R4 mode unchanged in extended", dispMode, 2'b10);
    wr(8'h5A);
    cmd(8'h20);
    check("R2 basic page again", extSet, 0);
    setPtr(5, 0);
    rdExpect(8'h5A, "R5 loads ignored in extended");

    // R5 out-of-range loads ignored (pointer now col6 page0)
    cmd(8'h80 | 8'd110);
    cmd(8'h4A);
    wr(8'h77);
    setPtr(6, 0);
    rdExpect(8'h77, "R5 out-of-range ignored");

    // R8 vertical addressing
    cmd(8'h22);
    check("R2 vertical flag", vertAddr, 1);
    setPtr(101, 7);
    wr(8'h11);
    wr(8'h22);
    wr(8'h33);
    cmd(8'h20);
    setPtr(101, 7);
    rdExpect(8'h11, "R8 col101 page7");
    setPtr(101, 8);
    rdExpect(8'h22, "R8 page step to 8");
    setPtr(0, 0);
    rdExpect(8'h33, "R8 page wrap with column wrap");
    cmd(8'h22);
    setPtr(4, 2);
    wr(8'h44);
    wr(8'h55);
    cmd(8'h20);
    setPtr(4, 3);
    rdExpect(8'h55, "R8 page step keeps column");

    // R9 power-down
    cmd(8'h24);
    check("R9 display off in power-down", dispMode, 0);
    statExpect(status(1,1,0,0,0,1), "R3 status keeps mode in power-down");
    setPtr(50, 4);
    wr(8'hC3);
    setPtr(50, 4);
    rdExpect(8'hC3, "R9 write/read in power-down");
    setPtr(0, 0);
    rdExpect(8'h33, "R9 contents kept");
    cmd(8'h20);
    check("R9 mode restored on wake", dispMode, 2'b10);

    // R10 remaining mode encodings
    cmd(8'h0D);
    check("R10 inverse mode", dispMode, 2'b11);
    cmd(8'h09);
    check("R10 all-on mode", dispMode, 2'b01);
    cmd(8'h08);
    check("R10 off mode", dispMode, 2'b00);
    cmd(8'h38);
    check("R2 row mirror set", scanRowRev, 1);
    statExpect(status(0,0,0,1,1,0), "R3 status both mirrors");

    repeat (3) @(negedge clk);
    finish();
  end

endmodule